// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block collects every interrupt source of a single UART channel and turns them into one interrupt line and one 6-bit status code. Each source is qualified by a bit of an 8-bit enable register. The upper four enable bits take effect only while the enhanced-features input is high. The channel's receive path, transmit path, line-status logic and modem-status logic drive strobes and levels into the block. The host reads the status code to learn which source needs service.

The receive character-time timeout lives inside the block, as does the edge detection on the CTS# and RTS# pin levels. Two small state machines do the work. The timeout timer has the states TO_IDLE, TO_RUN and TO_FIRED. It moves TO_IDLE→TO_RUN when the receive FIFO becomes armed, and TO_RUN→TO_RUN (restart) on a received character or a FIFO read. It moves TO_RUN→TO_FIRED when the count reaches its limit, and returns TO_RUN/TO_FIRED→TO_IDLE when the FIFO is disarmed or, from TO_FIRED, on a restart.

The arbiter has the states AR_IDLE and AR_HOLD. It moves AR_IDLE→AR_HOLD when any gated source is active, and latches the top one. It stays AR_HOLD→AR_HOLD (keep) while the latched source is still active. It moves AR_HOLD→AR_HOLD (advance) to the next top source once the latched source goes away. It returns AR_HOLD→AR_IDLE when nothing is active.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset the enable register is all zero, isr_code is 6'h01, irq is 0 and sleep_req is 0, so no source can raise irq until it is enabled.
- R2: Status codes are: line status 6'h06, receive timeout 6'h0C, receive data 6'h04, transmit ready 6'h02, modem 6'h00, Xoff/special 6'h10, CTS#/RTS# pin 6'h20, and none 6'h01. When several gated sources are active, the one reported is the first in that list.
- R3: Once a source is reported, isr_code holds it while that source stays active, even if a higher source appears. When it goes inactive, the highest remaining active source is reported, or 6'h01 if none is left. irq is 1 exactly when isr_code bit 0 is 0.
- R4: The line-status source is set when rx_char_strobe is high with any lsr_err bit set. It is cleared by lsr_rd and gated by enable bit 2.
- R5: While enh_en is 0, enable bits 4 to 7 have no effect: sleep_req = enable bit 4 AND enh_en, and the codes 6'h10 and 6'h20 are never reported.
- R6: The transmit source is set on a rising edge of the transmit condition (tx_below_trig when fifo_mode=1, tx_hold_empty otherwise). It is also set when enable bit 1 goes from 0 to 1 while the condition is high. It is gated by enable bit 1 and cleared by thr_wr or by an isr_rd while 6'h02 is reported.
- R7: The pin source is set by a low-to-high edge of cts_pin while auto_cts_en=1, or of rts_pin while auto_rts_en=1. A held-high pin sets it once only. The CTS part is gated by enable bit 7 and the RTS part by enable bit 6. Both are cleared by an isr_rd while 6'h20 is reported.
- R8: The receive-data source follows a level: rx_at_trig when fifo_mode=1, rx_hold_full otherwise. It is gated by enable bit 0.
- R9: The timeout is armed while fifo_mode=1, rx_fifo_nonempty=1 and rx_at_trig=0. It fires after OVS*(4*char_len+12) baud_tick strobes, restarts on rx_char_strobe or rx_read_strobe, clears when disarmed, and is gated by enable bit 0.
- R10: The modem source is set when any msr_delta bit is high. It is cleared by msr_rd and gated by enable bit 3.
- R11: The Xoff/special source is set by xoff_det. It is gated by enable bit 5 and enh_en, and cleared by an isr_rd while 6'h10 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced-features enable; unlocks enable bits 4 to 7 |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single holding register mode |
| rx_hold_full | input | 1 | Receive holding register has a character (non-FIFO mode) |
| rx_at_trig | input | 1 | Receive FIFO level at or above trigger |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_char_strobe | input | 1 | One-cycle strobe: a character was received |
| rx_read_strobe | input | 1 | One-cycle strobe: host read the receive FIFO |
| lsr_err | input | 4 | Error bits of the received character, valid with rx_char_strobe |
| lsr_rd | input | 1 | Host read of line status |
| tx_hold_empty | input | 1 | Transmit holding register empty (non-FIFO mode) |
| tx_below_trig | input | 1 | Transmit FIFO below its trigger level |
| thr_wr | input | 1 | Host write to the transmit holding register |
| msr_delta | input | 4 | Modem-status change bits |
| msr_rd | input | 1 | Host read of modem status |
| xoff_det | input | 1 | Xoff or special character detected |
| cts_pin | input | 1 | CTS# pin level |
| rts_pin | input | 1 | RTS# pin level |
| auto_cts_en | input | 1 | Automatic CTS flow control active |
| auto_rts_en | input | 1 | Automatic RTS flow control active |
| baud_tick | input | 1 | Oversampled baud strobe |
| char_len | input | LEN_W | Bits per character frame |
| isr_rd | input | 1 | Host read of the status code |
| isr_code | output | 6 | Reported source code |
| irq | output | 1 | Interrupt request |
| sleep_req | output | 1 | Effective sleep enable |

## Verification
The bench builds the block with OVS=2 and LEN_W=4. With OVS=2, a timeout window lasts under a hundred cycles, so every frame length from 4 to 9 bits is timed to the exact firing edge, both with and without a restart in the middle. The small enable register lets the bench sweep all 256 enable values with enh_en at both levels, in two pending-source configurations (receive data present, or timeout fired). Each reported code is compared with a priority computed from the enable value.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC  = 7;
    localparam int IDX_W = 3;
    localparam int EN_W  = 8;
    localparam int CODE_W = 6;

    // Index order is priority order: index 0 wins.
    typedef enum logic [IDX_W-1:0] {
        SRC_LINE = 3'd0,
        SRC_RXTO = 3'd1,
        SRC_RXD  = 3'd2,
        SRC_TX   = 3'd3,
        SRC_MDM  = 3'd4,
        SRC_XOFF = 3'd5,
        SRC_PIN  = 3'd6
    } src_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'h01;

    function automatic logic [CODE_W-1:0] src_code(input src_e s);
        logic [CODE_W-1:0] c;
        unique case (s)
            SRC_LINE: c = 6'h06;
            SRC_RXTO: c = 6'h0C;
            SRC_RXD:  c = 6'h04;
            SRC_TX:   c = 6'h02;
            SRC_MDM:  c = 6'h00;
            SRC_XOFF: c = 6'h10;
            SRC_PIN:  c = 6'h20;
            default:  c = CODE_NONE;
        endcase
        return c;
    endfunction

    function automatic src_e top_src(input logic [NSRC-1:0] act);
        src_e r;
        r = SRC_LINE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) r = src_e'(i[IDX_W-1:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/uirq_rise_det.sv
module uirq_rise_det #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= {WIDTH{RST_VAL}};
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_chk
        // A held-high level yields a single edge.
        p_rise_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
    parameter int OVS       = 16,
    parameter int LEN_W     = 4,
    parameter int CHARS     = 4,
    parameter int XTRA_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             restart,
    input  logic             baud_tick,
    input  logic [LEN_W-1:0] char_len,
    output logic             expired
);

    localparam int PRE_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int CNT_W = LEN_W + $clog2(CHARS) + 2;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(OVS - 1);

    typedef enum logic [1:0] {TO_IDLE, TO_RUN, TO_FIRED} to_st_e;

    to_st_e           st_q, st_d;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             bit_tick;

    assign limit    = CNT_W'(char_len) * CNT_W'(CHARS) + CNT_W'(XTRA_BITS);
    assign bit_tick = (st_q == TO_RUN) && baud_tick && (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TO_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (st_q != TO_RUN || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (baud_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TO_IDLE:  if (arm) st_d = TO_RUN;
            TO_RUN: begin
                if (!arm)                                         st_d = TO_IDLE;
                else if (restart)                                 st_d = TO_RUN;
                else if (bit_tick && cnt_q == limit - CNT_W'(1))  st_d = TO_FIRED;
            end
            TO_FIRED: if (!arm || restart) st_d = TO_IDLE;
            default:  st_d = TO_IDLE;
        endcase
    end

    assign expired = (st_q == TO_FIRED);

    p_fire_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == TO_FIRED) |-> ($past(cnt_q) == $past(limit) - CNT_W'(1)));

    p_no_fire_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (st_q != TO_FIRED));

endmodule

// File: rtl/uirq_arbiter.sv
module uirq_arbiter
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   active,
    output logic [CODE_W-1:0] code,
    output logic              irq,
    output src_e              cur_src
);

    typedef enum logic {AR_IDLE, AR_HOLD} ar_st_e;

    ar_st_e st_q, st_d;
    src_e   held_q, held_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= AR_IDLE;
            held_q <= SRC_LINE;
        end else begin
            st_q   <= st_d;
            held_q <= held_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        held_d = held_q;
        unique case (st_q)
            AR_IDLE: begin
                if (|active) begin
                    st_d   = AR_HOLD;
                    held_d = top_src(active);
                end
            end
            AR_HOLD: begin
                if (!active[held_q]) begin
                    if (|active) held_d = top_src(active);
                    else         st_d   = AR_IDLE;
                end
            end
            default: st_d = AR_IDLE;
        endcase
    end

    always_comb begin
        irq     = (st_q == AR_HOLD);
        code    = irq ? src_code(held_q) : CODE_NONE;
        cur_src = held_q;
    end

    p_hold_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AR_HOLD && active[held_q]) |=> (irq && held_q == $past(held_q)));

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AR_IDLE && !(|active)) |=> (!irq && code == CODE_NONE));

endmodule

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer
    import uirq_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic              enh_en,
    input  logic              fifo_mode,
    input  logic              rx_hold_full,
    input  logic              rx_at_trig,
    input  logic              rx_fifo_nonempty,
    input  logic              rx_char_strobe,
    input  logic              rx_read_strobe,
    input  logic [3:0]        lsr_err,
    input  logic              lsr_rd,
    input  logic              tx_hold_empty,
    input  logic              tx_below_trig,
    input  logic              thr_wr,
    input  logic [3:0]        msr_delta,
    input  logic              msr_rd,
    input  logic              xoff_det,
    input  logic              cts_pin,
    input  logic              rts_pin,
    input  logic              auto_cts_en,
    input  logic              auto_rts_en,
    input  logic              baud_tick,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              isr_rd,
    output logic [CODE_W-1:0] isr_code,
    output logic              irq,
    output logic              sleep_req
);

    localparam int EDGE_N = 4;

    logic [EN_W-1:0]   en_q;
    logic [EDGE_N-1:0] lvl, rise;
    logic              tx_cond, tx_set, rxd_lvl, to_arm, to_restart, to_exp;
    logic              line_q, tx_q, mdm_q, xoff_q, cts_q, rts_q;
    logic [NSRC-1:0]   active;
    src_e              cur_src;
    logic              rd_tx, rd_xoff, rd_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    assign tx_cond = fifo_mode ? tx_below_trig : tx_hold_empty;
    assign lvl     = {tx_cond, en_q[1], rts_pin, cts_pin};

    uirq_rise_det #(.WIDTH(EDGE_N), .RST_VAL(1'b1)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    assign tx_set     = rise[3] | (rise[2] & tx_cond);
    assign to_arm     = fifo_mode & rx_fifo_nonempty & ~rx_at_trig;
    assign to_restart = rx_char_strobe | rx_read_strobe;
    assign rxd_lvl    = fifo_mode ? rx_at_trig : rx_hold_full;

    uirq_rx_timeout #(.OVS(OVS), .LEN_W(LEN_W), .CHARS(4), .XTRA_BITS(12)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (to_arm),
        .restart   (to_restart),
        .baud_tick (baud_tick),
        .char_len  (char_len),
        .expired   (to_exp)
    );

    // Clears tied to a status read of the reported source.
    assign rd_tx   = isr_rd & irq & (cur_src == SRC_TX);
    assign rd_xoff = isr_rd & irq & (cur_src == SRC_XOFF);
    assign rd_pin  = isr_rd & irq & (cur_src == SRC_PIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            tx_q   <= 1'b0;
            mdm_q  <= 1'b0;
            xoff_q <= 1'b0;
            cts_q  <= 1'b0;
            rts_q  <= 1'b0;
        end else begin
            if (rx_char_strobe && |lsr_err) line_q <= 1'b1;
            else if (lsr_rd)                line_q <= 1'b0;

            if (tx_set)                tx_q <= 1'b1;
            else if (thr_wr || rd_tx)  tx_q <= 1'b0;

            if (|msr_delta)  mdm_q <= 1'b1;
            else if (msr_rd) mdm_q <= 1'b0;

            if (xoff_det)     xoff_q <= 1'b1;
            else if (rd_xoff) xoff_q <= 1'b0;

            if (rise[0] && auto_cts_en) cts_q <= 1'b1;
            else if (rd_pin)            cts_q <= 1'b0;

            if (rise[1] && auto_rts_en) rts_q <= 1'b1;
            else if (rd_pin)            rts_q <= 1'b0;
        end
    end

    always_comb begin
        active           = '0;
        active[SRC_LINE] = line_q  & en_q[2];
        active[SRC_RXTO] = to_exp  & en_q[0];
        active[SRC_RXD]  = rxd_lvl & en_q[0];
        active[SRC_TX]   = tx_q    & en_q[1];
        active[SRC_MDM]  = mdm_q   & en_q[3];
        active[SRC_XOFF] = xoff_q  & en_q[5] & enh_en;
        active[SRC_PIN]  = ((cts_q & en_q[7]) | (rts_q & en_q[6])) & enh_en;
    end

    assign sleep_req = en_q[4] & enh_en;

    uirq_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .code    (isr_code),
        .irq     (irq),
        .cur_src (cur_src)
    );

    p_line_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_strobe && |lsr_err) |=> line_q);

    p_tx_write_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_set) |=> !tx_q);

    p_modem_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|msr_delta) |=> mdm_q);

    p_ext_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_en && !$past(enh_en)) |-> (isr_code != 6'h10 && isr_code != 6'h20));

endmodule

// File: tb/uart_irq_prioritizer_bench.sv
module uart_irq_prioritizer_bench;

    localparam int OVS_TB = 2;
    localparam int LEN_TB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic enh_en = 1'b0, fifo_mode = 1'b0, rx_hold_full = 1'b0, rx_at_trig = 1'b0;
    logic rx_fifo_nonempty = 1'b0, rx_char_strobe = 1'b0, rx_read_strobe = 1'b0;
    logic [3:0] lsr_err = '0;
    logic lsr_rd = 1'b0, tx_hold_empty = 1'b0, tx_below_trig = 1'b0, thr_wr = 1'b0;
    logic [3:0] msr_delta = '0;
    logic msr_rd = 1'b0, xoff_det = 1'b0, cts_pin = 1'b0, rts_pin = 1'b0;
    logic auto_cts_en = 1'b0, auto_rts_en = 1'b0, baud_tick = 1'b0;
    logic [LEN_TB-1:0] char_len = '0;
    logic isr_rd = 1'b0;
    logic [5:0] isr_code;
    logic irq, sleep_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_prioritizer #(.OVS(OVS_TB), .LEN_W(LEN_TB)) u_uart_irq_prioritizer (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .enh_en(enh_en),
        .fifo_mode(fifo_mode), .rx_hold_full(rx_hold_full), .rx_at_trig(rx_at_trig),
        .rx_fifo_nonempty(rx_fifo_nonempty), .rx_char_strobe(rx_char_strobe),
        .rx_read_strobe(rx_read_strobe), .lsr_err(lsr_err), .lsr_rd(lsr_rd),
        .tx_hold_empty(tx_hold_empty), .tx_below_trig(tx_below_trig), .thr_wr(thr_wr),
        .msr_delta(msr_delta), .msr_rd(msr_rd), .xoff_det(xoff_det), .cts_pin(cts_pin),
        .rts_pin(rts_pin), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .baud_tick(baud_tick), .char_len(char_len), .isr_rd(isr_rd),
        .isr_code(isr_code), .irq(irq), .sleep_req(sleep_req)
    );

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk6(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_wdata = v;
        en_wr = 1'b1;
        nclk(1);
        en_wr = 1'b0;
    endtask

    task automatic pulse_isr_rd();
        isr_rd = 1'b1; nclk(1); isr_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en_wr = 0; en_wdata = 0; enh_en = 0; fifo_mode = 0; rx_hold_full = 0; rx_at_trig = 0;
        rx_fifo_nonempty = 0; rx_char_strobe = 0; rx_read_strobe = 0; lsr_err = 0; lsr_rd = 0;
        tx_hold_empty = 0; tx_below_trig = 0; thr_wr = 0; msr_delta = 0; msr_rd = 0;
        xoff_det = 0; cts_pin = 0; rts_pin = 0; auto_cts_en = 0; auto_rts_en = 0;
        baud_tick = 0; char_len = 0; isr_rd = 0;
        nclk(3);
        rst_n = 1'b1;
        nclk(2);
    endtask

    // Priority model taken from the code list of R2 and the gating of R5.
    function automatic logic [5:0] exp_code(input logic [7:0] e, input logic enh, input logic ph_b);
        if (e[2])                  return 6'h06;
        if (e[0] && ph_b)          return 6'h0C;
        if (e[0] && !ph_b)         return 6'h04;
        if (e[1])                  return 6'h02;
        if (e[3])                  return 6'h00;
        if (e[5] && enh)           return 6'h10;
        if ((e[6] || e[7]) && enh) return 6'h20;
        return 6'h01;
    endfunction

    task automatic sweep(input logic ph_b);
        for (int h = 0; h < 2; h++) begin
            enh_en = h[0];
            for (int e = 0; e < 256; e++) begin
                wr_en(8'h00);
                nclk(1);
                wr_en(e[7:0]);
                nclk(2);
                chk6(h[0] ? "R2 sweep code" : "R5 sweep code", isr_code, exp_code(e[7:0], h[0], ph_b));
                chk1("R3 sweep irq", irq, exp_code(e[7:0], h[0], ph_b) != 6'h01);
                chk1("R5 sweep sleep_req", sleep_req, e[4] & h[0]);
            end
        end
        wr_en(8'h00);
        enh_en = 1'b0;
        nclk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: reset state, and sources present with enables still zero.
        chk6("R1 reset code", isr_code, 6'h01);
        chk1("R1 reset irq", irq, 1'b0);
        chk1("R1 reset sleep_req", sleep_req, 1'b0);
        tx_hold_empty = 1'b1; rx_hold_full = 1'b1;
        rx_char_strobe = 1'b1; lsr_err = 4'b0010; nclk(1); rx_char_strobe = 1'b0; lsr_err = 0;
        nclk(3);
        chk1("R1 disabled sources quiet", irq, 1'b0);

        // Full enable sweep, phase A: non-FIFO, receive data present.
        do_reset();
        auto_cts_en = 1'b1; auto_rts_en = 1'b1;
        rx_hold_full = 1'b1;
        rx_char_strobe = 1'b1; lsr_err = 4'b0100; nclk(1); rx_char_strobe = 1'b0; lsr_err = 0;
        msr_delta = 4'b0001; nclk(1); msr_delta = 0;
        xoff_det = 1'b1; nclk(1); xoff_det = 1'b0;
        cts_pin = 1'b1; rts_pin = 1'b1; tx_hold_empty = 1'b1; tx_below_trig = 1'b1;
        nclk(3);
        sweep(1'b0);

        // Phase B: FIFO mode, timeout fired, no receive-data level.
        fifo_mode = 1'b1; rx_at_trig = 1'b0; rx_fifo_nonempty = 1'b1;
        baud_tick = 1'b1; char_len = 4'd5;
        nclk(100);
        sweep(1'b1);

        // R3, R4, R6: hold behaviour and clears.
        do_reset();
        wr_en(8'h06);
        tx_hold_empty = 1'b1;
        nclk(3);
        chk6("R6 tx reported", isr_code, 6'h02);
        rx_char_strobe = 1'b1; lsr_err = 4'b0001; nclk(1); rx_char_strobe = 1'b0; lsr_err = 0;
        nclk(3);
        chk6("R3 lower source held", isr_code, 6'h02);
        pulse_isr_rd();
        nclk(3);
        chk6("R3 advance after tx read clear", isr_code, 6'h06);
        lsr_rd = 1'b1; nclk(1); lsr_rd = 1'b0;
        nclk(3);
        chk6("R4 line cleared by lsr_rd", isr_code, 6'h01);
        chk1("R3 irq low when none", irq, 1'b0);

        // R6: holding register write clears the transmit source.
        tx_hold_empty = 1'b0; nclk(2);
        tx_hold_empty = 1'b1; nclk(3);
        chk6("R6 tx re-raised on edge", isr_code, 6'h02);
        thr_wr = 1'b1; tx_hold_empty = 1'b0; nclk(1); thr_wr = 1'b0;
        nclk(3);
        chk6("R6 tx cleared by thr_wr", isr_code, 6'h01);

        // R6: enabling while already empty raises the source.
        wr_en(8'h00);
        tx_hold_empty = 1'b1; nclk(2);
        thr_wr = 1'b1; nclk(1); thr_wr = 1'b0;
        nclk(2);
        wr_en(8'h02);
        nclk(4);
        chk6("R6 enable rise while empty", isr_code, 6'h02);
        pulse_isr_rd();
        nclk(3);
        chk6("R6 tx cleared by status read", isr_code, 6'h01);

        // R10: modem source.
        wr_en(8'h08);
        msr_delta = 4'b1000; nclk(1); msr_delta = 0;
        nclk(3);
        chk6("R10 modem reported", isr_code, 6'h00);
        chk1("R10 modem irq", irq, 1'b1);
        msr_rd = 1'b1; nclk(1); msr_rd = 1'b0;
        nclk(3);
        chk6("R10 modem cleared", isr_code, 6'h01);

        // R5, R11: Xoff source needs enh_en; cleared by a reporting read.
        wr_en(8'h20);
        xoff_det = 1'b1; nclk(1); xoff_det = 1'b0;
        nclk(3);
        chk6("R5 xoff masked without enh_en", isr_code, 6'h01);
        enh_en = 1'b1;
        nclk(3);
        chk6("R11 xoff reported", isr_code, 6'h10);
        pulse_isr_rd();
        nclk(3);
        chk6("R11 xoff cleared by read", isr_code, 6'h01);

        // R7: pin edges.
        wr_en(8'h80);
        auto_cts_en = 1'b0;
        cts_pin = 1'b1; nclk(3);
        chk6("R7 cts edge ignored without auto", isr_code, 6'h01);
        cts_pin = 1'b0; nclk(2);
        auto_cts_en = 1'b1;
        cts_pin = 1'b1; nclk(3);
        chk6("R7 cts edge reported", isr_code, 6'h20);
        pulse_isr_rd();
        nclk(3);
        chk6("R7 pin cleared by read, level held", isr_code, 6'h01);
        wr_en(8'h40);
        auto_rts_en = 1'b1;
        rts_pin = 1'b1; nclk(3);
        chk6("R7 rts edge reported", isr_code, 6'h20);
        pulse_isr_rd();
        nclk(3);
        chk6("R7 rts cleared", isr_code, 6'h01);
        enh_en = 1'b0;

        // R8: receive data level in non-FIFO mode.
        wr_en(8'h01);
        rx_hold_full = 1'b1; nclk(3);
        chk6("R8 rx data reported", isr_code, 6'h04);
        rx_hold_full = 1'b0; nclk(3);
        chk6("R8 rx data follows level", isr_code, 6'h01);

        // R9: timeout firing edge across frame lengths.
        fifo_mode = 1'b1; baud_tick = 1'b1; rx_at_trig = 1'b0;
        nclk(2);
        for (int len = 4; len <= 9; len++) begin
            char_len = LEN_TB'(len);
            rx_fifo_nonempty = 1'b1;
            nclk(OVS_TB * (4 * len + 12) + 1);
            chk1("R9 quiet before limit", irq, 1'b0);
            nclk(1);
            chk6("R9 timeout at limit", isr_code, 6'h0C);
            rx_fifo_nonempty = 1'b0;
            nclk(3);
            chk6("R9 cleared on disarm", isr_code, 6'h01);
        end

        // R9: restart by a FIFO read.
        char_len = 4'd5;
        rx_fifo_nonempty = 1'b1;
        nclk(20);
        rx_read_strobe = 1'b1; nclk(1); rx_read_strobe = 1'b0;
        nclk(OVS_TB * 32);
        chk1("R9 restart delays timeout", irq, 1'b0);
        nclk(1);
        chk6("R9 timeout after restart", isr_code, 6'h0C);

        // R8: reaching the trigger disarms the timer; data level takes over.
        rx_at_trig = 1'b1;
        nclk(3);
        chk6("R8 trigger level replaces timeout", isr_code, 6'h04);
        rx_at_trig = 1'b0; rx_fifo_nonempty = 1'b0;
        nclk(3);
        chk6("R8 level gone", isr_code, 6'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule